// File: doc/BRIEF.md
# Round-Robin Bank Refresh Scheduler

This block keeps track of the refresh work owed by the banks of one memory channel. A period timer counts memory cycles. Each time a full period has elapsed, the block adds one obligation to a pending count. Expirations add up, so a busy channel can defer several refreshes and pay them back later.

While any obligation is pending, the block raises a request aimed at one bank, named by a rotating pointer. It also drives a one-hot head vector, so the bank arbiter can treat the refresh as the request at the head of that bank's queue. When the arbiter accepts the refresh, the count drops by one and the pointer steps to the next bank.

A fixed-latency mode freezes the timer, so no new obligations arise in that mode. Letting the pending count climb to its limit is reported as a sticky overrun.

Top module: `rfsh_rr_sched`

## Requirements
- R1: While reset is held (synchronous, active low) and in the first cycle after it, `rfsh_req_o` and `overrun_o` are 0, `tgt_bank_o` is 0, `head_vec_o` is all zeros and the timer holds the full value of `period_i`.
- R2: Without fixed mode, one obligation is added every max(`period_i`,1) cycles. The first is added on the `period_i`-th rising edge after reset is released. A cycle in which an expiration and an accept coincide leaves the pending count unchanged.
- R3: An expiration that would bring the pending count to `OVR_LIMIT` (default 10) without a same-cycle accept is dropped. The count stays at `OVR_LIMIT`-1, and `overrun_o` sets and stays set until reset.
- R4: While `fixed_lat_i` is 1, the timer holds its value and adds no obligations. Obligations already pending can still be accepted.
- R5: Each accepted refresh moves `tgt_bank_o` on by one. After bank `NUM_BANKS`-1 it returns to 0.
- R6: `rfsh_req_o` is 1 exactly when the pending count is nonzero. `head_vec_o` then has only bit `tgt_bank_o` set; otherwise it is all zeros.
- R7: `rfsh_ack_i` has no effect while `rfsh_req_o` is 0. The bank pointer and the pending count are unchanged.
- R8: `rfsh_req_o` falls in the cycle after the accept that clears the last pending obligation. The number of accepted cycles equals the number of obligations that were pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| fixed_lat_i | input | 1 | Fixed-latency mode; freezes the refresh timer |
| period_i | input | PERIOD_W | Refresh period in cycles (0 behaves as 1) |
| rfsh_ack_i | input | 1 | Arbiter accepted the refresh this cycle |
| rfsh_req_o | output | 1 | A refresh obligation is pending |
| tgt_bank_o | output | BANK_W | Bank the pending refresh is aimed at |
| head_vec_o | output | NUM_BANKS | One-hot pseudo head-of-queue marker per bank |
| overrun_o | output | 1 | Sticky pending-count overrun flag |

## Verification
The bench builds the block with NUM_BANKS set to 5 and keeps PERIOD_W at 8. The odd bank count exercises the compare-and-wrap pointer variant rather than the power-of-two wrap. With the default OVR_LIMIT of 10 and short periods, the saturation point and the sticky overrun are reached within a few dozen cycles. A period of 1 with the accept held high makes an expiration and an accept coincide on every edge. The accept is also driven while nothing is pending, to show it has no effect.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/rfsh_period_timer.sv
module rfsh_period_timer #(
   parameter int unsigned PERIOD_W = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                freeze_i,
   input  logic [PERIOD_W-1:0] period_i,
   output logic                expire_o
);
   logic [PERIOD_W-1:0] remain_q;
   logic                at_end;

   assign at_end   = (remain_q <= PERIOD_W'(1));
   assign expire_o = at_end && !freeze_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)          remain_q <= period_i;
      else if (!freeze_i) begin
         if (at_end)        remain_q <= period_i;
         else               remain_q <= remain_q - PERIOD_W'(1);
      end
   end

   AST_TIMER_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      freeze_i |=> (remain_q == $past(remain_q))); // R4

   AST_TIMER_NO_EXPIRE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      freeze_i |-> !expire_o); // R4
endmodule

// File: rtl/rfsh_pending_ctr.sv
module rfsh_pending_ctr #(
   parameter int unsigned OVR_LIMIT = 10,
   parameter int unsigned PEND_W    = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              inc_i,
   input  logic              dec_i,
   output logic [PEND_W-1:0] pend_o,
   output logic              overrun_o
);
   localparam logic [PEND_W-1:0] TOP_VAL = PEND_W'(OVR_LIMIT - 1);

   logic [PEND_W-1:0] pend_q;
   logic              ovr_q;
   logic              would_spill;

   assign would_spill = inc_i && !dec_i && (pend_q == TOP_VAL);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pend_q <= '0;
         ovr_q  <= 1'b0;
      end else begin
         if (would_spill)         ovr_q  <= 1'b1;
         else if (inc_i && !dec_i) pend_q <= pend_q + PEND_W'(1);
         else if (dec_i && !inc_i) pend_q <= pend_q - PEND_W'(1);
      end
   end

   assign pend_o    = pend_q;
   assign overrun_o = ovr_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_q <= TOP_VAL); // R3

   AST_OVERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovr_q |=> ovr_q); // R3

   AST_PEND_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && dec_i) |=> (pend_q == $past(pend_q))); // R2

   AST_NO_DEC_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q == '0) |-> !dec_i); // R7
endmodule

// File: rtl/rfsh_bank_ptr.sv
module rfsh_bank_ptr #(
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned BANK_W    = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              step_i,
   output logic [BANK_W-1:0] ptr_o
);
   localparam logic [BANK_W-1:0] LAST = BANK_W'(NUM_BANKS - 1);

   logic [BANK_W-1:0] ptr_q;
   logic [BANK_W-1:0] ptr_nxt;

   generate
      if (NUM_BANKS == (1 << BANK_W)) begin : g_pow2_wrap
         assign ptr_nxt = ptr_q + BANK_W'(1);
      end else begin : g_cmp_wrap
         assign ptr_nxt = (ptr_q == LAST) ? '0 : ptr_q + BANK_W'(1);
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     ptr_q <= '0;
      else if (step_i) ptr_q <= ptr_nxt;
   end

   assign ptr_o = ptr_q;

   AST_PTR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ptr_q <= LAST); // R5

   AST_PTR_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i |=> (ptr_q != $past(ptr_q))); // R5

   AST_PTR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !step_i |=> $stable(ptr_q)); // R7
endmodule

// File: rtl/rfsh_rr_sched.sv
module rfsh_rr_sched #(
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned PERIOD_W  = 8,
   parameter int unsigned OVR_LIMIT = 10,
   localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
   localparam int unsigned PEND_W   = rfsh_pkg::cnt_width(OVR_LIMIT)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 fixed_lat_i,
   input  logic [PERIOD_W-1:0]  period_i,
   input  logic                 rfsh_ack_i,
   output logic                 rfsh_req_o,
   output logic [BANK_W-1:0]    tgt_bank_o,
   output logic [NUM_BANKS-1:0] head_vec_o,
   output logic                 overrun_o
);
   initial begin
      if (NUM_BANKS < 2)  $error("NUM_BANKS must be at least 2");
      if (OVR_LIMIT < 2)  $error("OVR_LIMIT must be at least 2");
      if (PERIOD_W < 1)   $error("PERIOD_W must be at least 1");
   end

   logic              expire;
   logic              taken;
   logic [PEND_W-1:0] pend;

   rfsh_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .freeze_i (fixed_lat_i),
      .period_i (period_i),
      .expire_o (expire)
   );

   assign rfsh_req_o = (pend != '0);
   assign taken      = rfsh_req_o && rfsh_ack_i;

   rfsh_pending_ctr #(.OVR_LIMIT(OVR_LIMIT), .PEND_W(PEND_W)) u_pend (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (expire),
      .dec_i     (taken),
      .pend_o    (pend),
      .overrun_o (overrun_o)
   );

   rfsh_bank_ptr #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (taken),
      .ptr_o  (tgt_bank_o)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_head
         assign head_vec_o[b] = rfsh_req_o && (tgt_bank_o == BANK_W'(b));
      end
   endgenerate

   AST_HEAD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(head_vec_o) && (rfsh_req_o == (head_vec_o != '0))); // R6

   AST_REQ_AFTER_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expire && !rfsh_ack_i) |=> rfsh_req_o); // R2
endmodule

// File: tb/rfsh_rr_sched_tb_top.sv
`timescale 1ns/1ps
module rfsh_rr_sched_tb_top;
   localparam int NB = 5;
   localparam int PW = 8;
   localparam int LIM = 10;
   localparam int BW = $clog2(NB);
   localparam int NV = 9;
   localparam int VEC_P [NV] = '{4, 4, 4, 1, 3, 3, 7, 0, 200};
   localparam int VEC_N [NV] = '{3, 4, 13, 7, 30, 29, 49, 5, 150};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fixed = 1'b0;
   logic [PW-1:0] period = '0;
   logic          ack = 1'b0;
   logic          req;
   logic [BW-1:0] bank;
   logic [NB-1:0] head;
   logic          ovr;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   rfsh_rr_sched #(.NUM_BANKS(NB), .PERIOD_W(PW), .OVR_LIMIT(LIM)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .fixed_lat_i(fixed), .period_i(period),
      .rfsh_ack_i(ack), .rfsh_req_o(req), .tgt_bank_o(bank),
      .head_vec_o(head), .overrun_o(ovr)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(input int p, input bit fx);
      @(negedge clk);
      rst_n = 1'b0; ack = 1'b0; fixed = fx; period = PW'(p);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic drain(output int cnt);
      fixed = 1'b1;
      ack = 1'b1;
      cnt = 0;
      for (int k = 0; k < 20; k++) begin
         if (!req) break;
         @(negedge clk);
         cnt++;
      end
      ack = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int got;
      // R1: reset state, sampled in the first cycle after release
      do_reset(6, 1'b0);
      chk(req == 1'b0, "R1 req after reset", req, 0);
      chk(bank == '0, "R1 bank after reset", bank, 0);
      chk(head == '0, "R1 head after reset", head, 0);
      chk(ovr == 1'b0, "R1 overrun after reset", ovr, 0);

      // R2 R3 R5 R6 R8: table of (period, cycles) vectors
      for (int v = 0; v < NV; v++) begin
         int eff, raw, exp_p;
         bit exp_o;
         eff   = (VEC_P[v] == 0) ? 1 : VEC_P[v];
         raw   = VEC_N[v] / eff;
         exp_p = (raw >= LIM) ? LIM - 1 : raw;
         exp_o = (raw >= LIM);
         do_reset(VEC_P[v], 1'b0);
         repeat (VEC_N[v]) @(negedge clk);
         fixed = 1'b1;
         chk(req == (exp_p > 0), "R2 req after run", req, exp_p > 0);
         chk(ovr == exp_o, "R3 overrun flag", ovr, exp_o);
         chk(head == ((exp_p > 0) ? NB'(1) : NB'(0)), "R6 head vector", head,
             (exp_p > 0) ? 1 : 0);
         drain(got);
         chk(got == exp_p, "R8 accepted count equals pending", got, exp_p);
         chk(req == 1'b0, "R8 req low after drain", req, 0);
         chk(bank == BW'(exp_p % NB), "R5 bank after drain", bank, exp_p % NB);
         chk(ovr == exp_o, "R3 overrun stays", ovr, exp_o);
      end

      // R4: fixed mode from reset adds nothing
      do_reset(2, 1'b1);
      repeat (20) @(negedge clk);
      chk(req == 1'b0, "R4 no obligation in fixed mode", req, 0);

      // R7: accept with nothing pending is ignored
      ack = 1'b1;
      repeat (5) @(negedge clk);
      ack = 1'b0;
      chk(bank == '0, "R7 bank unchanged by stray accept", bank, 0);
      chk(req == 1'b0, "R7 no request after stray accept", req, 0);
      chk(head == '0, "R7 head stays empty", head, 0);

      // R4: pending obligations still drain once fixed mode is entered
      do_reset(2, 1'b0);
      repeat (6) @(negedge clk);
      fixed = 1'b1;
      repeat (10) @(negedge clk);
      drain(got);
      chk(got == 3, "R4 frozen count drains", got, 3);

      // R2 R5: expiry and accept every edge (period 1, accept held)
      do_reset(1, 1'b0);
      ack = 1'b1;
      repeat (12) @(negedge clk);
      fixed = 1'b1;
      chk(req == 1'b1, "R2 coincident expiry and accept keeps one pending", req, 1);
      chk(bank == BW'(11 % NB), "R5 bank wraps under steady accepts", bank, 11 % NB);
      chk(head == NB'(1 << (11 % NB)), "R6 head follows bank", head, 1 << (11 % NB));
      drain(got);
      chk(got == 1, "R8 one left to drain", got, 1);
      chk(bank == BW'(12 % NB), "R5 final bank", bank, 12 % NB);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule